// File: doc/BRIEF.md
# Regulator Fault Qualification Monitor

This block watches the digitized sense values of a two-rail voltage regulator controller and decides when an abnormal reading has lasted long enough to count as a fault. The main rail runs with one, two or three phases. For that rail the block checks the summed output current, the output voltage excess over its setpoint, and the spread between the per-phase current samples. For the single-phase auxiliary rail it checks the summed current and the voltage excess. Each check has its own threshold and its own persistence time. Persistence is counted in pulses of a tick input, so the same logic serves a real time base or a scaled one in test.

The overcurrent limit of the main rail depends jointly on the number of active phases and on the power-state code. A fault that qualifies is latched, and it raises a request to pull that rail's power-good low. Every fault is cleared only by dropping the enable input.

Each fault is qualified by its own small state machine:
- `Q_IDLE`: the condition is absent and the count is zero.
- `Q_ARMED`: the condition is present and ticks are being counted.
- `Q_TRIPPED`: the fault is latched.

The transitions are as follows:
- From `Q_IDLE` or `Q_ARMED`, a sampled condition with a tick advances the count, or goes to `Q_TRIPPED` on the final tick.
- From `Q_IDLE` or `Q_ARMED`, a condition without a tick goes to or stays in `Q_ARMED` with the count held.
- From `Q_IDLE` or `Q_ARMED`, a cleared condition returns to `Q_IDLE` with the count at zero.
- From any state, enable low returns to `Q_IDLE`.

Top module: `fltq_monitor`

## Requirements
- R1: With `phase_cnt`=3, the main-rail overcurrent limit is 60 for `pstate`=0, 40 for `pstate`=1, and 20 for `pstate`=2 or 3.
- R2: With `phase_cnt`=2, the main-rail overcurrent limit is 60 for `pstate`=0 and 30 for `pstate`=1, 2 or 3.
- R3: With `phase_cnt`=1 or 0, the main-rail limit is 60 in every power state. The auxiliary-rail limit is always 60.
- R4: A rail's overvoltage fault qualifies when its excess input is above 175. It uses its own persistence count `OV_TICKS` (default 2).
- R5: An imbalance fault qualifies when the largest minus the smallest per-phase sample among the active phases is above 2, for `IMB_TICKS` ticks (default 32). Phase 0 occupies the low byte of `phase_isen`. The active phases are 0..1 for `phase_cnt`=2 and 0..2 for `phase_cnt`=3. With `phase_cnt` of 1 or 0 there is never an imbalance.
- R6: Persistence works as follows. A fault latches at the clock edge of the N-th tick seen with its condition true, provided the condition was also true at every edge in between. A single edge with the condition false restarts the count from zero. Edges without a tick do not count. The overcurrent count is `OC_TICKS` (default 4).
- R7: Once latched, a fault stays set while enable is high, even after its condition clears.
- R8: At the first edge with enable low, all faults clear. While enable is low nothing counts, and after re-enable a full count is needed again.
- R9: `main_pg_low` is the OR of the three main-rail faults. `aux_pg_low` is the OR of the two auxiliary faults. One rail's faults never affect the other rail's request.
- R10: All comparisons are strict, so a value equal to its limit never qualifies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Rail enable; low clears all faults |
| tick | input | 1 | Time-base pulse that advances persistence counts |
| phase_cnt | input | 2 | Active main-rail phases (0 treated as 1) |
| pstate | input | 2 | Power-state code 0..3 |
| main_isum | input | I_W | Main-rail summed current sample |
| aux_isum | input | I_W | Auxiliary-rail summed current sample |
| main_ov_excess | input | V_W | Main-rail output voltage above setpoint |
| aux_ov_excess | input | V_W | Auxiliary-rail output voltage above setpoint |
| phase_isen | input | N_PH*S_W | Packed per-phase current samples |
| main_oc_fault | output | 1 | Main-rail overcurrent latched |
| main_ov_fault | output | 1 | Main-rail overvoltage latched |
| main_imb_fault | output | 1 | Main-rail current imbalance latched |
| aux_oc_fault | output | 1 | Auxiliary-rail overcurrent latched |
| aux_ov_fault | output | 1 | Auxiliary-rail overvoltage latched |
| main_pg_low | output | 1 | Main-rail power-good low request |
| aux_pg_low | output | 1 | Auxiliary-rail power-good low request |

## Verification
The bench drives every input just after a falling edge, so each rising edge samples a stable condition. With a tick on every cycle, a fault needing N ticks is visible at the falling edge after the N-th rising edge. The bench checks one falling edge before that point for zero and then at that point for one. A clear caused by enable low shows after a single rising edge, so it is checked one cycle after enable drops.

// File: rtl/fltq_pkg.sv
package fltq_pkg;

    typedef enum logic [1:0] {
        Q_IDLE    = 2'd0,
        Q_ARMED   = 2'd1,
        Q_TRIPPED = 2'd2
    } qual_state_e;

endpackage

// File: rtl/fltq_qualifier.sv
module fltq_qualifier
    import fltq_pkg::*;
#(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic cond,
    output logic fault
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    qual_state_e    state, state_nx;
    logic [CW-1:0]  cnt, cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (!enable) begin
            state_nx = Q_IDLE;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                Q_IDLE, Q_ARMED: begin
                    if (!cond) begin
                        state_nx = Q_IDLE;
                        cnt_nx   = '0;
                    end else if (tick) begin
                        if (cnt == LAST) begin
                            state_nx = Q_TRIPPED;
                            cnt_nx   = '0;
                        end else begin
                            state_nx = Q_ARMED;
                            cnt_nx   = cnt + 1'b1;
                        end
                    end else begin
                        state_nx = Q_ARMED;
                    end
                end
                Q_TRIPPED: begin
                    state_nx = Q_TRIPPED;
                end
                default: begin
                    state_nx = Q_IDLE;
                    cnt_nx   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= Q_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        fault = (state == Q_TRIPPED);
    end

    // R8: disable clears at the next edge
    p_clear_on_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !fault);
    // R7: latched while enabled
    p_fault_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && enable) |=> fault);
    // R6: a trip only follows a tick with the condition present
    p_trip_needs_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> $past(tick && cond && enable));
    // R6: count stays below its limit
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R6: condition loss restarts counting
    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cond && !fault) |=> (cnt == '0) && !fault);

endmodule

// File: rtl/fltq_spread.sv
module fltq_spread #(
    parameter int N_PH   = 3,
    parameter int S_W    = 8,
    parameter int MARGIN = 2
) (
    input  logic [1:0]          phase_cnt,
    input  logic [N_PH*S_W-1:0] phase_isen,
    output logic                over
);
    logic [S_W-1:0] hi, lo, smp;
    int             n_act;

    always_comb begin
        n_act = (phase_cnt == 2'd0) ? 1 : int'(phase_cnt);
        if (n_act > N_PH) n_act = N_PH;
        hi = phase_isen[S_W-1:0];
        lo = phase_isen[S_W-1:0];
        for (int i = 1; i < N_PH; i++) begin
            smp = phase_isen[i*S_W +: S_W];
            if (i < n_act) begin
                if (smp > hi) hi = smp;
                if (smp < lo) lo = smp;
            end
        end
        over = (n_act > 1) && ((hi - lo) > S_W'(MARGIN));
    end

endmodule

// File: rtl/fltq_monitor.sv
module fltq_monitor
    import fltq_pkg::*;
#(
    parameter int N_PH       = 3,
    parameter int I_W        = 8,
    parameter int V_W        = 10,
    parameter int S_W        = 8,
    parameter int OC_FULL    = 60,
    parameter int OC_MID3    = 40,
    parameter int OC_LOW3    = 20,
    parameter int OC_LOW2    = 30,
    parameter int OV_MARGIN  = 175,
    parameter int IMB_MARGIN = 2,
    parameter int OC_TICKS   = 4,
    parameter int OV_TICKS   = 2,
    parameter int IMB_TICKS  = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                tick,
    input  logic [1:0]          phase_cnt,
    input  logic [1:0]          pstate,
    input  logic [I_W-1:0]      main_isum,
    input  logic [I_W-1:0]      aux_isum,
    input  logic [V_W-1:0]      main_ov_excess,
    input  logic [V_W-1:0]      aux_ov_excess,
    input  logic [N_PH*S_W-1:0] phase_isen,
    output logic                main_oc_fault,
    output logic                main_ov_fault,
    output logic                main_imb_fault,
    output logic                aux_oc_fault,
    output logic                aux_ov_fault,
    output logic                main_pg_low,
    output logic                aux_pg_low
);
    localparam int N_RAIL = 2;

    logic [I_W-1:0]    main_limit;
    logic [N_RAIL-1:0] oc_cond, ov_cond, oc_flt, ov_flt;
    logic              imb_cond;
    logic [I_W-1:0]    isum   [N_RAIL];
    logic [I_W-1:0]    limit  [N_RAIL];
    logic [V_W-1:0]    excess [N_RAIL];

    always_comb begin
        unique case (phase_cnt)
            2'd3: begin
                unique case (pstate)
                    2'd0:    main_limit = I_W'(OC_FULL);
                    2'd1:    main_limit = I_W'(OC_MID3);
                    default: main_limit = I_W'(OC_LOW3);
                endcase
            end
            2'd2:    main_limit = (pstate == 2'd0) ? I_W'(OC_FULL) : I_W'(OC_LOW2);
            default: main_limit = I_W'(OC_FULL);
        endcase
    end

    always_comb begin
        isum[0]   = main_isum;
        isum[1]   = aux_isum;
        limit[0]  = main_limit;
        limit[1]  = I_W'(OC_FULL);
        excess[0] = main_ov_excess;
        excess[1] = aux_ov_excess;
    end

    for (genvar r = 0; r < N_RAIL; r++) begin : g_rail
        assign oc_cond[r] = isum[r] > limit[r];
        assign ov_cond[r] = excess[r] > V_W'(OV_MARGIN);

        fltq_qualifier #(.LIMIT(OC_TICKS)) u_oc (
            .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
            .cond(oc_cond[r]), .fault(oc_flt[r]));

        fltq_qualifier #(.LIMIT(OV_TICKS)) u_ov (
            .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
            .cond(ov_cond[r]), .fault(ov_flt[r]));
    end

    fltq_spread #(.N_PH(N_PH), .S_W(S_W), .MARGIN(IMB_MARGIN)) u_spread (
        .phase_cnt(phase_cnt), .phase_isen(phase_isen), .over(imb_cond));

    fltq_qualifier #(.LIMIT(IMB_TICKS)) u_imb (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .cond(imb_cond), .fault(main_imb_fault));

    always_comb begin
        main_oc_fault = oc_flt[0];
        aux_oc_fault  = oc_flt[1];
        main_ov_fault = ov_flt[0];
        aux_ov_fault  = ov_flt[1];
        main_pg_low   = main_oc_fault | main_ov_fault | main_imb_fault;
        aux_pg_low    = aux_oc_fault | aux_ov_fault;
    end

    // R5: imbalance needs at least two active phases
    p_imb_needs_phases_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_imb_fault) |-> $past(phase_cnt >= 2'd2));
    // R8: both power-good requests release after disable
    p_pg_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !main_pg_low && !aux_pg_low);
    // R10: a main overcurrent trip follows a current above the active limit
    p_oc_strict_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_oc_fault) |-> $past(main_isum > I_W'(OC_LOW3)));

endmodule

// File: tb/fltq_monitor_tb.sv
module fltq_monitor_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int OC_T  = 4;
    localparam int OV_T  = 2;
    localparam int IMB_T = 32;

    logic        clk = 0, rst_n = 0, enable = 0, tick = 0;
    logic [1:0]  phase_cnt = 2'd3, pstate = 2'd0;
    logic [7:0]  main_isum = 0, aux_isum = 0;
    logic [9:0]  main_ov_excess = 0, aux_ov_excess = 0;
    logic [23:0] phase_isen = 0;
    logic main_oc_fault, main_ov_fault, main_imb_fault;
    logic aux_oc_fault, aux_ov_fault, main_pg_low, aux_pg_low;

    int errors = 0, checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fltq_monitor #(.OC_TICKS(OC_T), .OV_TICKS(OV_T), .IMB_TICKS(IMB_T)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
        .phase_cnt(phase_cnt), .pstate(pstate),
        .main_isum(main_isum), .aux_isum(aux_isum),
        .main_ov_excess(main_ov_excess), .aux_ov_excess(aux_ov_excess),
        .phase_isen(phase_isen),
        .main_oc_fault(main_oc_fault), .main_ov_fault(main_ov_fault),
        .main_imb_fault(main_imb_fault), .aux_oc_fault(aux_oc_fault),
        .aux_ov_fault(aux_ov_fault), .main_pg_low(main_pg_low),
        .aux_pg_low(aux_pg_low));

    typedef struct packed {
        logic [1:0] ph;
        logic [1:0] ps;
        logic [7:0] cur;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{2'd3, 2'd0, 8'd60, 1'b0, 4'd10}, // R10 equal to limit
        '{2'd3, 2'd0, 8'd61, 1'b1, 4'd1},  // R1
        '{2'd3, 2'd1, 8'd40, 1'b0, 4'd10}, // R10
        '{2'd3, 2'd1, 8'd41, 1'b1, 4'd1},  // R1
        '{2'd3, 2'd2, 8'd20, 1'b0, 4'd10}, // R10
        '{2'd3, 2'd2, 8'd21, 1'b1, 4'd1},  // R1
        '{2'd3, 2'd3, 8'd21, 1'b1, 4'd1},  // R1 pstate 3
        '{2'd2, 2'd0, 8'd61, 1'b1, 4'd2},  // R2
        '{2'd2, 2'd0, 8'd60, 1'b0, 4'd2},  // R2
        '{2'd2, 2'd1, 8'd31, 1'b1, 4'd2},  // R2
        '{2'd2, 2'd2, 8'd30, 1'b0, 4'd2},  // R2
        '{2'd2, 2'd2, 8'd31, 1'b1, 4'd2},  // R2
        '{2'd1, 2'd2, 8'd61, 1'b1, 4'd3},  // R3
        '{2'd1, 2'd2, 8'd41, 1'b0, 4'd3},  // R3
        '{2'd1, 2'd1, 8'd60, 1'b0, 4'd3},  // R3
        '{2'd0, 2'd2, 8'd61, 1'b1, 4'd3}   // R3
    };

    task automatic chk(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        enable = 0; main_isum = 0; aux_isum = 0;
        main_ov_excess = 0; aux_ov_excess = 0; phase_isen = 0;
        step(1);
        enable = 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(2);
        // reset state
        chk(main_pg_low | aux_pg_low | main_oc_fault | main_imb_fault, 1'b0, "R9", "reset outputs");
        rst_n = 1;
        tick  = 1;
        step(1);

        // table walk: overcurrent limits
        for (int k = 0; k < NV; k++) begin
            clear_all();
            phase_cnt = VEC[k].ph; pstate = VEC[k].ps; main_isum = VEC[k].cur;
            step(OC_T);
            chk(main_oc_fault, VEC[k].exp, $sformatf("R%0d", VEC[k].req), $sformatf("oc vec %0d", k));
            chk(main_pg_low, VEC[k].exp, "R9", $sformatf("pg vec %0d", k));
        end

        // R3: aux limit fixed at 60 regardless of main mode
        clear_all(); phase_cnt = 2'd3; pstate = 2'd2; aux_isum = 8'd41;
        step(OC_T);
        chk(aux_oc_fault, 1'b0, "R3", "aux 41");
        aux_isum = 8'd61; step(OC_T);
        chk(aux_oc_fault, 1'b1, "R3", "aux 61");
        chk(main_pg_low, 1'b0, "R9", "aux fault leaves main pg");
        chk(aux_pg_low, 1'b1, "R9", "aux pg");

        // R4: overvoltage
        clear_all(); main_ov_excess = 10'd175; step(OV_T + 3);
        chk(main_ov_fault, 1'b0, "R4", "ov equal 175");
        main_ov_excess = 10'd176; step(OV_T - 1);
        chk(main_ov_fault, 1'b0, "R4", "ov one short");
        step(1);
        chk(main_ov_fault, 1'b1, "R4", "ov main");
        chk(aux_pg_low, 1'b0, "R9", "main ov leaves aux pg");
        clear_all(); aux_ov_excess = 10'd300; step(OV_T);
        chk(aux_ov_fault, 1'b1, "R4", "ov aux");
        chk(main_pg_low, 1'b0, "R9", "aux ov leaves main pg");

        // R6: restart on a gap, ticks gate counting
        clear_all(); phase_cnt = 2'd3; pstate = 2'd0; main_isum = 8'd61;
        step(OC_T - 1);
        chk(main_oc_fault, 1'b0, "R6", "one short");
        main_isum = 8'd0; step(1);
        main_isum = 8'd61; step(OC_T - 1);
        chk(main_oc_fault, 1'b0, "R6", "restarted count");
        step(1);
        chk(main_oc_fault, 1'b1, "R6", "full count after restart");
        clear_all(); tick = 0; main_isum = 8'd61; step(20);
        chk(main_oc_fault, 1'b0, "R6", "no tick no count");
        tick = 1; step(OC_T);
        chk(main_oc_fault, 1'b1, "R6", "ticks resume");

        // R7: latched after condition clears
        main_isum = 8'd0; step(10);
        chk(main_oc_fault, 1'b1, "R7", "latched oc");
        chk(main_pg_low, 1'b1, "R7", "latched pg");

        // R8: clear on disable, no counting while low
        enable = 0; step(1);
        chk(main_oc_fault, 1'b0, "R8", "cleared");
        main_isum = 8'd61; step(10);
        chk(main_oc_fault, 1'b0, "R8", "no count while disabled");
        enable = 1; step(OC_T - 1);
        chk(main_oc_fault, 1'b0, "R8", "full count after enable");
        step(1);
        chk(main_oc_fault, 1'b1, "R8", "trip after enable");

        // R5: imbalance
        clear_all(); phase_cnt = 2'd3;
        phase_isen = {8'd12, 8'd10, 8'd10}; step(IMB_T + 4);
        chk(main_imb_fault, 1'b0, "R5", "spread 2");
        phase_isen = {8'd13, 8'd10, 8'd10}; step(IMB_T - 1);
        chk(main_imb_fault, 1'b0, "R5", "spread 3 one short");
        step(1);
        chk(main_imb_fault, 1'b1, "R5", "spread 3 trips");
        chk(main_pg_low, 1'b1, "R9", "imb pg");
        clear_all(); phase_cnt = 2'd2;
        phase_isen = {8'd50, 8'd10, 8'd10}; step(IMB_T + 4);
        chk(main_imb_fault, 1'b0, "R5", "phase 2 inactive");
        phase_isen = {8'd10, 8'd14, 8'd10}; step(IMB_T);
        chk(main_imb_fault, 1'b1, "R5", "two-phase spread");
        clear_all(); phase_cnt = 2'd1;
        phase_isen = {8'd90, 8'd90, 8'd10}; step(IMB_T + 4);
        chk(main_imb_fault, 1'b0, "R5", "single phase never");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule